// File: doc/BRIEF.md
# Half Butterfly Half Rotator

A radix-2 processing element for one-sample-per-cycle FFT pipelines. The two operands of a butterfly come in on back-to-back cycles, the first (X0) tagged by a pair-start input and the second (X1) on the cycle after it. The block returns the undisturbed sum Y0 = X0 + X1 and the rotated difference Y1 = (X0 − X1)·(cos + j·sin), also on back-to-back cycles, with Y0 first.

The arithmetic is half of a conventional butterfly and complex multiplier. A single real add/subtract pair handles the real parts in one cycle and the imaginary parts in the next. A single pair of real multipliers and one combining adder produce the real part of the rotation in one cycle and the imaginary part in the next. Only the difference is rotated, so in a continuous stream every unit is busy on every cycle. Twiddle generation and stream reordering are left to the neighbouring stages.

Data are 16-bit two's complement. Twiddle factors are Q1.14, so 16384 means 1.0. The difference is kept at 17 bits into the rotator. The products are rounded back to 16 bits, and both outputs saturate.

Top module: `hbhr_pe`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair emerges, `dout_re_o`, `dout_im_o` and `dout_first_o` are 0.
- R2: Input schedule. X0 is presented with `pair_first_i` = 1. X1 follows on the next cycle with `pair_first_i` = 0. `cos_i`/`sin_i` are sampled only in the X1 cycle, and their values in any other cycle have no effect on the outputs. Pair starts are at least two cycles apart, so `pair_first_i` is never high on two consecutive cycles.
- R3: Y0 appears 3 cycles after the X0 cycle. Its real part is the 16-bit saturated value of X0.re + X1.re, and its imaginary part is the 16-bit saturated value of X0.im + X1.im.
- R4: Y1 appears on the cycle after Y0, with ZR = X0.re − X1.re and ZI = X0.im − X1.im, each exact at 17 bits. Y1.re = sat16((ZR·cos − ZI·sin + 8192) >>> 14) and Y1.im = sat16((ZR·sin + ZI·cos + 8192) >>> 14). An independent model is checked to within ±1 LSB.
- R5: `dout_first_o` is 1 for exactly the Y0 cycle of each pair and 0 on every other cycle.
- R6: Pairs may start every two cycles with no idle cycle between them. Each pair's results are unaffected by its neighbours.
- R7: On any cycle that is neither a Y0 cycle nor a Y1 cycle, both data outputs hold their previous values.
- R8: Trivial rotations are exact. With cos = 16384 and sin = 0, Y1 = (sat16(ZR), sat16(ZI)). With cos = 0 and sin = −16384, Y1 = (sat16(ZI), sat16(−ZR)).
- R9: Saturation is symmetric. A result above 32767 gives 32767 and a result below −32768 gives −32768, for both the sums and the rotated difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_first_i | input | 1 | High in the cycle carrying X0 |
| din_re_i | input | 16 | Real part of the input sample |
| din_im_i | input | 16 | Imaginary part of the input sample |
| cos_i | input | 16 | Twiddle cosine, Q1.14, sampled in the X1 cycle |
| sin_i | input | 16 | Twiddle sine, Q1.14, sampled in the X1 cycle |
| dout_re_o | output | 16 | Real part of the output sample |
| dout_im_o | output | 16 | Imaginary part of the output sample |
| dout_first_o | output | 1 | High in the cycle carrying Y0 |

## Verification
The bound checker watches several properties on every clock:
- the spacing of pair starts;
- the fixed three-cycle delay from a pair start to its Y0 marker, in both directions;
- the marker lasting a single cycle;
- the outputs holding between pairs;
- the saturated sum on both parts of Y0, against the delayed inputs.

The rotated half cannot be written as a short property, because it depends on twiddles captured mid-pair. Only the bench scenarios show that it is right. These include random angles, the exact trivial angles, rotations that saturate, twiddle noise outside the capture cycle, and dense back-to-back streams.

// File: rtl/hbhr_pkg.sv
package hbhr_pkg;

  localparam int HB_DW    = 16;
  localparam int HB_TW    = 16;
  localparam int HB_TFRAC = 14;

  // which half of a complex value a shared unit is working on this cycle
  typedef enum logic {
    PART_REAL = 1'b0,
    PART_IMAG = 1'b1
  } hb_part_e;

endpackage

// File: rtl/hbhr_addsub.sv
module hbhr_addsub #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] sum_o,
  output logic signed [DW:0]   diff_o
);

  localparam int XW = DW + 1;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [XW-1:0] a_x;
  logic signed [XW-1:0] b_x;
  logic signed [XW-1:0] sum_x;

  always_comb begin
    a_x    = XW'(a_i);
    b_x    = XW'(b_i);
    sum_x  = a_x + b_x;
    diff_o = a_x - b_x;
    if (sum_x[XW-1] != sum_x[XW-2]) begin
      sum_o = sum_x[XW-1] ? MINV : MAXV;
    end else begin
      sum_o = sum_x[DW-1:0];
    end
  end

endmodule

// File: rtl/hbhr_rotmac.sv
module hbhr_rotmac
  import hbhr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ZW    = 17,
  parameter int TW    = 16,
  parameter int TFRAC = 14,
  parameter bit ROUND = 1'b1
) (
  input  hb_part_e             part_i,
  input  logic signed [ZW-1:0] za_i,
  input  logic signed [ZW-1:0] zb_i,
  input  logic signed [TW-1:0] ta_i,
  input  logic signed [TW-1:0] tb_i,
  output logic signed [DW-1:0] y_o
);

  localparam int PW = ZW + TW;
  localparam int AW = PW + 1;
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW-1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW-1));

  logic signed [PW-1:0] za_x, zb_x, ta_x, tb_x;
  logic signed [PW-1:0] prod_a, prod_b;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] biased;
  logic signed [AW-1:0] scaled;

  always_comb begin
    za_x   = PW'(za_i);
    zb_x   = PW'(zb_i);
    ta_x   = PW'(ta_i);
    tb_x   = PW'(tb_i);
    prod_a = za_x * ta_x;
    prod_b = zb_x * tb_x;
    if (part_i == PART_REAL) begin
      acc = AW'(prod_a) - AW'(prod_b);
    end else begin
      acc = AW'(prod_a) + AW'(prod_b);
    end
  end

  generate
    if (ROUND) begin : g_round
      localparam logic signed [AW-1:0] BIAS = AW'(1) <<< (TFRAC-1);
      assign biased = acc + BIAS;
    end else begin : g_trunc
      assign biased = acc;
    end
  endgenerate

  always_comb begin
    scaled = biased >>> TFRAC;
    if (scaled > MAXV) begin
      y_o = MAXV[DW-1:0];
    end else if (scaled < MINV) begin
      y_o = MINV[DW-1:0];
    end else begin
      y_o = scaled[DW-1:0];
    end
  end

endmodule

// File: rtl/hbhr_pe.sv
module hbhr_pe
  import hbhr_pkg::*;
#(
  parameter int DW    = HB_DW,
  parameter int TW    = HB_TW,
  parameter int TFRAC = HB_TFRAC,
  parameter bit ROUND = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pair_first_i,
  input  logic signed [DW-1:0] din_re_i,
  input  logic signed [DW-1:0] din_im_i,
  input  logic signed [TW-1:0] cos_i,
  input  logic signed [TW-1:0] sin_i,
  output logic signed [DW-1:0] dout_re_o,
  output logic signed [DW-1:0] dout_im_o,
  output logic                 dout_first_o
);

  localparam int ZW = DW + 1;

  // pair phase pipeline: f1 = X1 cycle, f2 = one later, f3 = two later
  logic ph1_q, ph2_q, ph3_q;

  logic signed [DW-1:0] x0re_q, x0im_q, x1im_q;
  logic signed [TW-1:0] tc_q, ts_q;
  logic signed [ZW-1:0] zr_q, zi_q;
  logic signed [DW-1:0] yr0_q, yr1_q;
  logic signed [DW-1:0] ore_q, oim_q;
  logic                 ofirst_q;

  logic signed [DW-1:0] ore_d, oim_d;
  logic                 x0_en, mid_en, late_en, out_en;

  hb_part_e             bf_part, rot_part;
  logic signed [DW-1:0] bf_a, bf_b, bf_sum;
  logic signed [ZW-1:0] bf_diff;
  logic signed [ZW-1:0] rot_zb;
  logic signed [TW-1:0] rot_ta, rot_tb;
  logic signed [DW-1:0] rot_y;

  // operand steering for the shared units
  always_comb begin
    bf_part  = ph2_q ? PART_IMAG : PART_REAL;
    rot_part = ph3_q ? PART_IMAG : PART_REAL;
    bf_a     = (bf_part == PART_IMAG) ? x0im_q : x0re_q;
    bf_b     = (bf_part == PART_IMAG) ? x1im_q : din_re_i;
    // real rotation runs alongside the imaginary difference (not yet stored)
    rot_zb   = (rot_part == PART_IMAG) ? zi_q : bf_diff;
    rot_ta   = (rot_part == PART_IMAG) ? ts_q : tc_q;
    rot_tb   = (rot_part == PART_IMAG) ? tc_q : ts_q;
  end

  hbhr_addsub #(.DW(DW)) u_bfly (
    .a_i    (bf_a),
    .b_i    (bf_b),
    .sum_o  (bf_sum),
    .diff_o (bf_diff)
  );

  hbhr_rotmac #(
    .DW    (DW),
    .ZW    (ZW),
    .TW    (TW),
    .TFRAC (TFRAC),
    .ROUND (ROUND)
  ) u_rot (
    .part_i (rot_part),
    .za_i   (zr_q),
    .zb_i   (rot_zb),
    .ta_i   (rot_ta),
    .tb_i   (rot_tb),
    .y_o    (rot_y)
  );

  // next-state and enables
  always_comb begin
    x0_en   = pair_first_i;
    mid_en  = ph1_q;
    late_en = ph2_q;
    out_en  = ph2_q | ph3_q;
    if (ph2_q) begin
      ore_d = yr0_q;
      oim_d = bf_sum;
    end else begin
      ore_d = yr1_q;
      oim_d = rot_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1_q    <= 1'b0;
      ph2_q    <= 1'b0;
      ph3_q    <= 1'b0;
      ofirst_q <= 1'b0;
    end else begin
      ph1_q    <= pair_first_i;
      ph2_q    <= ph1_q;
      ph3_q    <= ph2_q;
      ofirst_q <= ph2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0re_q <= '0;
      x0im_q <= '0;
    end else if (x0_en) begin
      x0re_q <= din_re_i;
      x0im_q <= din_im_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1im_q <= '0;
      tc_q   <= '0;
      ts_q   <= '0;
      zr_q   <= '0;
      yr0_q  <= '0;
    end else if (mid_en) begin
      x1im_q <= din_im_i;
      tc_q   <= cos_i;
      ts_q   <= sin_i;
      zr_q   <= bf_diff;
      yr0_q  <= bf_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zi_q  <= '0;
      yr1_q <= '0;
    end else if (late_en) begin
      zi_q  <= bf_diff;
      yr1_q <= rot_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ore_q <= '0;
      oim_q <= '0;
    end else if (out_en) begin
      ore_q <= ore_d;
      oim_q <= oim_d;
    end
  end

  assign dout_re_o    = ore_q;
  assign dout_im_o    = oim_q;
  assign dout_first_o = ofirst_q;

endmodule

// File: rtl/hbhr_pe_chk.sv
module hbhr_pe_chk #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pair_first_i,
  input logic signed [DW-1:0] din_re_i,
  input logic signed [DW-1:0] din_im_i,
  input logic signed [TW-1:0] cos_i,
  input logic signed [TW-1:0] sin_i,
  input logic signed [DW-1:0] dout_re_o,
  input logic signed [DW-1:0] dout_im_o,
  input logic                 dout_first_o
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  function automatic logic signed [DW-1:0] sat_add(logic signed [DW-1:0] a,
                                                   logic signed [DW-1:0] b);
    logic signed [DW:0] s;
    s = (DW+1)'(a) + (DW+1)'(b);
    if (s > (DW+1)'((2 ** (DW-1)) - 1)) return {1'b0, {(DW-1){1'b1}}};
    if (s < -(DW+1)'(2 ** (DW-1)))      return {1'b1, {(DW-1){1'b0}}};
    return s[DW-1:0];
  endfunction

  AST_FIRST_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    pair_first_i |=> !pair_first_i); // R2

  AST_Y0_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    dout_first_o |-> $past(pair_first_i, 3)); // R3

  AST_START_TO_Y0: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(pair_first_i, 3)) |-> dout_first_o); // R6

  AST_MARK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_first_o |=> !dout_first_o); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_first_o && !$past(dout_first_o)) |-> ($stable(dout_re_o) && $stable(dout_im_o))); // R7

  AST_Y0_RE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    dout_first_o |-> dout_re_o == sat_add($past(din_re_i, 3), $past(din_re_i, 2))); // R3

  AST_Y0_IM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    dout_first_o |-> dout_im_o == sat_add($past(din_im_i, 3), $past(din_im_i, 2))); // R9

endmodule

bind hbhr_pe hbhr_pe_chk #(.DW(DW), .TW(TW)) u_hbhr_pe_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pair_first_i (pair_first_i),
  .din_re_i     (din_re_i),
  .din_im_i     (din_im_i),
  .cos_i        (cos_i),
  .sin_i        (sin_i),
  .dout_re_o    (dout_re_o),
  .dout_im_o    (dout_im_o),
  .dout_first_o (dout_first_o)
);

// File: tb/hbhr_pe_bench.sv
module hbhr_pe_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               pair_first;
  logic signed [15:0] din_re, din_im, cos_v, sin_v;
  logic signed [15:0] dout_re, dout_im;
  logic               dout_first;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    prev_re = 0;
  int    prev_im = 0;
  int    exp_kind [DEPTH];
  int    exp_re   [DEPTH];
  int    exp_im   [DEPTH];
  int    exp_tol  [DEPTH];
  string exp_tag  [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hbhr_pe u_hbhr_pe (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_first_i (pair_first),
    .din_re_i     (din_re),
    .din_im_i     (din_im),
    .cos_i        (cos_v),
    .sin_i        (sin_v),
    .dout_re_o    (dout_re),
    .dout_im_o    (dout_im),
    .dout_first_o (dout_first)
  );

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic longint rnd14(longint v);
    return (v + 8192) >>> 14;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, expv);
    end
  endtask

  task automatic check_now();
    int k;
    int a_re, a_im;
    k    = cyc;
    a_re = int'(dout_re);
    a_im = int'(dout_im);
    if (k < DEPTH && exp_kind[k] == 1) begin
      chk(dout_first == 1'b1, "R5", "Y0 marker", int'(dout_first), 1);
      chk(a_re == exp_re[k], exp_tag[k], "Y0 real", a_re, exp_re[k]);
      chk(a_im == exp_im[k], exp_tag[k], "Y0 imag", a_im, exp_im[k]);
    end else if (k < DEPTH && exp_kind[k] == 2) begin
      chk(dout_first == 1'b0, "R5", "marker on Y1", int'(dout_first), 0);
      chk((a_re - exp_re[k] <= exp_tol[k]) && (exp_re[k] - a_re <= exp_tol[k]),
          exp_tag[k], "Y1 real", a_re, exp_re[k]);
      chk((a_im - exp_im[k] <= exp_tol[k]) && (exp_im[k] - a_im <= exp_tol[k]),
          exp_tag[k], "Y1 imag", a_im, exp_im[k]);
    end else begin
      chk(dout_first == 1'b0, "R5", "idle marker", int'(dout_first), 0);
      chk(a_re == prev_re, "R7", "idle hold real", a_re, prev_re);
      chk(a_im == prev_im, "R7", "idle hold imag", a_im, prev_im);
    end
    prev_re = a_re;
    prev_im = a_im;
  endtask

  task automatic tick(logic f, int r, int i, int c, int s);
    @(negedge clk);
    check_now();
    pair_first = f;
    din_re     = 16'(r);
    din_im     = 16'(i);
    cos_v      = 16'(c);
    sin_v      = 16'(s);
  endtask

  function automatic int rnd_data();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  function automatic int rnd_tw();
    return int'($urandom_range(32768)) - 16384;
  endfunction

  // one pair followed by gap idle cycles with noise on data and twiddle
  task automatic send_pair(int x0r, int x0i, int x1r, int x1i, int c, int s,
                           int gap, int tol, string tag0, string tag1);
    longint zr, zi;
    int     k;
    zr = longint'(x0r) - longint'(x1r);
    zi = longint'(x0i) - longint'(x1i);
    tick(1'b1, x0r, x0i, rnd_tw(), rnd_tw());
    k = cyc;
    if (k + 4 < DEPTH) begin
      exp_kind[k+3] = 1;
      exp_re[k+3]   = sat16(longint'(x0r) + longint'(x1r));
      exp_im[k+3]   = sat16(longint'(x0i) + longint'(x1i));
      exp_tag[k+3]  = tag0;
      exp_kind[k+4] = 2;
      exp_re[k+4]   = sat16(rnd14(zr * c - zi * s));
      exp_im[k+4]   = sat16(rnd14(zr * s + zi * c));
      exp_tol[k+4]  = tol;
      exp_tag[k+4]  = tag1;
    end
    tick(1'b0, x1r, x1i, c, s);
    for (int g = 0; g < gap; g++) begin
      tick(1'b0, rnd_data(), rnd_data(), rnd_tw(), rnd_tw());
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n      = 1'b0;
    pair_first = 1'b0;
    din_re     = '0;
    din_im     = '0;
    cos_v      = '0;
    sin_v      = '0;
    repeat (3) @(negedge clk);
    chk(dout_re == 0, "R1", "reset real", int'(dout_re), 0);
    chk(dout_im == 0, "R1", "reset imag", int'(dout_im), 0);
    chk(dout_first == 0, "R1", "reset marker", int'(dout_first), 0);
    rst_n = 1'b1;
    repeat (2) tick(1'b0, 0, 0, 0, 0);
    chk(dout_re == 0 && dout_im == 0, "R1", "after release", int'(dout_re), 0);

    // trivial angles: unity and -j
    send_pair(100, -200, 30, 50, 16384, 0, 2, 0, "R3", "R8");
    send_pair(1000, 2000, -3000, 400, 0, -16384, 2, 0, "R3", "R8");
    send_pair(-32768, 32767, 32767, -32768, 0, -16384, 2, 0, "R9", "R8");
    // saturation of sums and of the rotated difference
    send_pair(32767, 32767, 32767, 32767, 16384, 0, 2, 0, "R9", "R9");
    send_pair(-32768, -32768, -32768, -32768, 16384, 0, 2, 0, "R9", "R9");
    send_pair(32767, 32767, -32768, -32768, 11585, 11585, 2, 1, "R9", "R9");
    send_pair(32767, -32768, -32768, 32767, 16384, 0, 2, 0, "R9", "R9");
    // dense stream with no idle cycles
    for (int n = 0; n < 6; n++) begin
      send_pair(rnd_data(), rnd_data(), rnd_data(), rnd_data(), rnd_tw(), rnd_tw(),
                0, 1, "R6", "R6");
    end
    // other spacings with twiddle noise outside the capture cycle
    send_pair(1234, -4321, 777, 999, 8192, -14189, 1, 1, "R3", "R2");
    send_pair(-5000, 6000, 7000, -8000, -11585, 11585, 3, 1, "R3", "R2");
    // random mix
    for (int n = 0; n < 400; n++) begin
      send_pair(rnd_data(), rnd_data(), rnd_data(), rnd_data(), rnd_tw(), rnd_tw(),
                int'($urandom_range(2)), 1, "R3", "R4");
    end
    repeat (6) tick(1'b0, rnd_data(), rnd_data(), rnd_tw(), rnd_tw());

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule